// File: doc/BRIEF.md
# Net-Graph Loop and Multi-Driver Checker

This block decides whether a small gate graph is a legal combinational network. Each gate is one vertex. A net becomes a set of edges, one from the gate that drives it to each gate it feeds. Software-side logic loads the graph one adjacency row per transfer. Row `i`, bit `j` set means an edge from vertex `i` to vertex `j`. A single `start` pulse then launches a check.

The check has two phases. The first phase scans the matrix column by column. It rejects the graph at once if any vertex has two or more incoming edges, because that means two nets drive one terminal. The second phase is an iterative depth-first search that uses an on-chip stack. Each stack entry holds a vertex and its next-successor pointer, and every vertex carries a 2-bit state: new, open (on the stack) or closed. One successor is examined per clock. An edge that reaches an open vertex is a back edge, and a back edge proves a loop. Search roots are taken in ascending vertex order among the vertices that are still new.

The row write port is valid/ready. A row transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole of a check, so rows offered during a check wait and are not written. `wr_valid` may stay high while it waits.

Top module: `netgraph_loop_chk`

## Requirements
- R1: A row is stored only on a clock edge where `wr_valid` and `wr_ready` are both high. The row number is `wr_row` and `wr_data` bit `j` is the edge to vertex `j`. Rows offered while `wr_ready` is low are not stored.
- R2: A `start` pulse while idle drops `done` and `wr_ready` on the next cycle. `start` during a check is ignored.
- R3: If any vertex has two or more incoming edges (a self-edge counts), the check ends with `done`=1, `multi_drive`=1 and `acyclic`=0.
- R4: If no vertex has more than one driver but the graph has a directed loop (a self-edge counts), the check ends with `done`=1, `acyclic`=0 and `multi_drive`=0.
- R5: If no vertex has more than one driver and the graph has no loop, the check ends with `done`=1, `acyclic`=1 and `multi_drive`=0. Edges into already closed vertices are not loops.
- R6: Once high, `done` stays high until the next accepted `start`, and `acyclic` and `multi_drive` hold still while it is high.
- R7: After reset, `done`, `acyclic` and `multi_drive` are 0, `wr_ready` is 1, and the matrix is empty, so a check run with no rows written reports acyclic.
- R8: A check ends within N*N+3N+4 cycles after `start`, and a multi-driver rejection ends within N+2 cycles. Both bounds hold even for a 16-deep chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Row write offered |
| wr_ready | output | 1 | Engine idle, row accepted |
| wr_row | input | $clog2(N) | Row (source vertex) number |
| wr_data | input | N | Successor bits of the row |
| start | input | 1 | One-cycle check launch |
| done | output | 1 | Check finished, result valid |
| acyclic | output | 1 | Graph is legal and loop-free |
| multi_drive | output | 1 | A vertex has more than one driver |

## Verification
The `done` and `wr_ready` drops are due one cycle after the `start` edge. The bench samples them on the following falling edge. The verdict latency depends on the graph, so the bench polls `done` on every falling edge and counts the cycles. It then compares the count with the R8 bounds and reads `acyclic` and `multi_drive` only in the first cycle `done` is high. The hold of R6 is checked over several later cycles, and rows offered during a check are confirmed as not stored by running the same graph again.

// File: rtl/netgraph_pkg.sv
package netgraph_pkg;
  typedef enum logic [1:0] {
    VS_NEW    = 2'd0,
    VS_OPEN   = 2'd1,
    VS_CLOSED = 2'd2
  } vstate_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FANIN = 2'd1,
    ST_ROOT  = 2'd2,
    ST_SCAN  = 2'd3
  } phase_e;
endpackage

// File: rtl/adj_matrix.sv
module adj_matrix #(
  parameter int N  = 16,
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [VW-1:0] waddr,
  input  logic [N-1:0]  wdata,
  input  logic [VW-1:0] raddr,
  input  logic [VW-1:0] caddr,
  output logic [N-1:0]  rrow,
  output logic [N-1:0]  ccol
);
  logic [N-1:0] rows [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rows[i] <= '0;
    end else if (we) begin
      rows[waddr] <= wdata;
    end
  end

  assign rrow = rows[raddr];

  for (genvar g = 0; g < N; g++) begin : g_col
    assign ccol[g] = rows[g][caddr];
  end
endmodule

// File: rtl/fanin_flag.sv
module fanin_flag #(
  parameter int N = 16
) (
  input  logic [N-1:0] col,
  output logic         multi
);
  logic seen;
  always_comb begin
    seen  = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (col[i]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfs_stack.sv
module dfs_stack #(
  parameter int N  = 16,
  parameter int VW = $clog2(N),
  parameter int PW = VW + 1,
  parameter int SW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [VW-1:0] push_v,
  input  logic          adv,
  input  logic          pop,
  output logic [VW-1:0] top_v,
  output logic [PW-1:0] top_p,
  output logic [SW-1:0] depth
);
  logic [VW-1:0] ent_v [N];
  logic [PW-1:0] ent_p [N];
  logic [VW-1:0] tidx;

  assign tidx  = VW'(depth - SW'(1));
  assign top_v = ent_v[tidx];
  assign top_p = ent_p[tidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < N; i++) begin
        ent_v[i] <= '0;
        ent_p[i] <= '0;
      end
    end else if (clr) begin
      depth <= '0;
    end else begin
      if (adv) ent_p[tidx] <= ent_p[tidx] + PW'(1);
      if (push) begin
        ent_v[VW'(depth)] <= push_v;
        ent_p[VW'(depth)] <= '0;
        depth <= depth + SW'(1);
      end else if (pop) begin
        depth <= depth - SW'(1);
      end
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (depth < SW'(N)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (depth != '0));
endmodule

// File: rtl/netgraph_loop_chk.sv
module netgraph_loop_chk
  import netgraph_pkg::*;
#(
  parameter int N  = 16,
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [VW-1:0] wr_row,
  input  logic [N-1:0]  wr_data,
  input  logic          start,
  output logic          done,
  output logic          acyclic,
  output logic          multi_drive
);
  localparam int PW = VW + 1;
  localparam int SW = $clog2(N + 1);
  localparam int BOUND = N * N + 3 * N + 4;
  localparam int CW = $clog2(BOUND + 2);
  localparam logic [PW-1:0] P_END = PW'(N);

  phase_e        phase;
  vstate_e       vst [N];
  logic [VW-1:0] col;
  logic [PW-1:0] root;
  logic          done_q, acyc_q, multi_q;

  logic [N-1:0]  row_bits, col_bits;
  logic          col_multi;
  logic [VW-1:0] top_v, tgt, push_v;
  logic [PW-1:0] top_p;
  logic [SW-1:0] depth;
  logic          edge_hit, root_new, push, adv, pop, launch, scanning;

  assign wr_ready    = (phase == ST_IDLE);
  assign done        = done_q;
  assign acyclic     = acyc_q;
  assign multi_drive = multi_q;
  assign launch      = (phase == ST_IDLE) && start;

  adj_matrix #(.N(N), .VW(VW)) u_mat (
    .clk(clk), .rst_n(rst_n),
    .we(wr_valid && wr_ready), .waddr(wr_row), .wdata(wr_data),
    .raddr(top_v), .caddr(col), .rrow(row_bits), .ccol(col_bits)
  );

  fanin_flag #(.N(N)) u_fan (.col(col_bits), .multi(col_multi));

  dfs_stack #(.N(N), .VW(VW), .PW(PW), .SW(SW)) u_stk (
    .clk(clk), .rst_n(rst_n), .clr(launch),
    .push(push), .push_v(push_v), .adv(adv), .pop(pop),
    .top_v(top_v), .top_p(top_p), .depth(depth)
  );

  assign tgt      = top_p[VW-1:0];
  assign scanning = (phase == ST_SCAN) && (top_p != P_END);
  assign edge_hit = scanning && row_bits[tgt];
  assign root_new = (phase == ST_ROOT) && (root != P_END) && (vst[root[VW-1:0]] == VS_NEW);
  assign push     = root_new || (edge_hit && vst[tgt] == VS_NEW);
  assign push_v   = (phase == ST_ROOT) ? root[VW-1:0] : tgt;
  assign adv      = scanning && !(edge_hit && vst[tgt] == VS_OPEN);
  assign pop      = (phase == ST_SCAN) && (top_p == P_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_IDLE;
      col     <= '0;
      root    <= '0;
      done_q  <= 1'b0;
      acyc_q  <= 1'b0;
      multi_q <= 1'b0;
      for (int i = 0; i < N; i++) vst[i] <= VS_NEW;
    end else begin
      if (push) vst[push_v] <= VS_OPEN;
      unique case (phase)
        ST_IDLE: if (start) begin
          phase   <= ST_FANIN;
          col     <= '0;
          root    <= '0;
          done_q  <= 1'b0;
          acyc_q  <= 1'b0;
          multi_q <= 1'b0;
          for (int i = 0; i < N; i++) vst[i] <= VS_NEW;
        end
        ST_FANIN: begin
          if (col_multi) begin
            phase   <= ST_IDLE;
            done_q  <= 1'b1;
            multi_q <= 1'b1;
          end else if (col == VW'(N - 1)) begin
            phase <= ST_ROOT;
          end else begin
            col <= col + VW'(1);
          end
        end
        ST_ROOT: begin
          if (root == P_END) begin
            phase  <= ST_IDLE;
            done_q <= 1'b1;
            acyc_q <= 1'b1;
          end else begin
            root <= root + PW'(1);
            if (root_new) phase <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (pop) begin
            vst[top_v] <= VS_CLOSED;
            if (depth == SW'(1)) phase <= ST_ROOT;
          end else if (edge_hit && vst[tgt] == VS_OPEN) begin
            phase  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (launch)            run_cnt <= '0;
    else if (phase != ST_IDLE)  run_cnt <= run_cnt + CW'(1);
  end

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!done && !wr_ready));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(acyclic) && $stable(multi_drive)));

  // R3
  multi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && multi_drive) |-> !acyclic);

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != ST_IDLE) |-> (run_cnt <= CW'(BOUND)));

  // R1
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !done);
endmodule

// File: tb/netgraph_loop_chk_tb_top.sv
module netgraph_loop_chk_tb_top;
  localparam int N  = 16;
  localparam int VW = $clog2(N);
  localparam int LIMIT = N * N + 3 * N + 4;
  localparam int NV = 8;

  // edge lists: byte k = {src, dst}
  localparam logic [63:0] VEC_EDGES [NV] = '{
    64'h0,
    64'h33,
    64'h20_12_01,
    64'h12_02,
    64'h45_24_13_02_01,
    64'h35_43_54,
    64'hC7_AB_9A_78,
    64'h21_10_01
  };
  localparam int VEC_CNT [NV] = '{0, 1, 3, 2, 5, 3, 4, 3};
  localparam logic [NV-1:0] VEC_ACYC  = 8'h51;
  localparam logic [NV-1:0] VEC_MULTI = 8'h88;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [VW-1:0] wr_row = '0;
  logic [N-1:0] wr_data = '0;
  logic start = 1'b0;
  logic done, acyclic, multi_drive;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] g [N];

  always #5 clk = ~clk;

  netgraph_loop_chk #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_row(wr_row), .wr_data(wr_data), .start(start),
    .done(done), .acyclic(acyclic), .multi_drive(multi_drive)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_row(input int r, input logic [N-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_row   = VW'(r);
    wr_data  = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_graph();
    for (int r = 0; r < N; r++) write_row(r, g[r]);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && !wr_ready, "R2 done/ready low after start", {done, wr_ready}, 0);
    cyc = 1;
    while (!done && cyc <= LIMIT + 4) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc <= LIMIT, "R8 cycles to done", cyc, LIMIT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(!done && !acyclic && !multi_drive, "R7 reset outputs", {done, acyclic, multi_drive}, 0);
    check(wr_ready, "R7 reset wr_ready", wr_ready, 1);
    run(cyc);
    check(done && acyclic && !multi_drive, "R7 empty matrix after reset",
          {done, acyclic, multi_drive}, 3'b110);

    // table of graphs (R3, R4, R5)
    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < N; r++) g[r] = '0;
      for (int k = 0; k < VEC_CNT[v]; k++) begin
        g[VEC_EDGES[v][8*k+4 +: 4]][VEC_EDGES[v][8*k +: 4]] = 1'b1;
      end
      load_graph();
      run(cyc);
      check(done && acyclic == VEC_ACYC[v] && multi_drive == VEC_MULTI[v],
            $sformatf("R3/R4/R5 vector %0d", v),
            {done, acyclic, multi_drive}, {1'b1, VEC_ACYC[v], VEC_MULTI[v]});
      if (VEC_MULTI[v]) check(cyc <= N + 2, "R8 multi-driver early exit", cyc, N + 2);
    end

    // R6 hold
    repeat (5) @(negedge clk);
    check(done && !acyclic && multi_drive, "R6 result held", {done, acyclic, multi_drive}, 3'b101);

    // R5 full-depth chain, with R1 blocked write during the run
    for (int r = 0; r < N; r++) g[r] = (r < N - 1) ? (N'(1) << (r + 1)) : '0;
    load_graph();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wr_valid = 1'b1;
    wr_row = VW'(N - 1);
    wr_data = N'(1);
    check(!wr_ready, "R1 ready low during check", wr_ready, 0);
    cyc = 1;
    while (!done && cyc <= LIMIT + 4) begin
      @(negedge clk);
      cyc++;
    end
    wr_valid = 1'b0;
    check(done && acyclic && !multi_drive, "R5 16-deep chain", {done, acyclic, multi_drive}, 3'b110);
    check(cyc <= LIMIT, "R8 chain bound", cyc, LIMIT);
    run(cyc);
    check(acyclic, "R1 write during busy not stored", acyclic, 1);

    // R4 16-deep loop closing back to vertex 0
    write_row(N - 1, N'(1));
    run(cyc);
    check(done && !acyclic && !multi_drive, "R4 16-deep loop", {done, acyclic, multi_drive}, 3'b100);

    // R2 start ignored mid-run: result unaffected
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc <= LIMIT + 4) begin
      @(negedge clk);
      cyc++;
    end
    check(done && !acyclic, "R2 repeated start ignored while busy", {done, acyclic}, 2'b10);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule